// File: doc/BRIEF.md
# Supply Supervisor Reset Sequencer

This block turns two digital supply-comparator flags into the chip-wide reset. The primary flag reports supply below a high threshold. The secondary flag reports supply below a lower threshold, near 2.5 V. The sequencer asserts reset while supply is too low. Once supply is back above the high threshold, it counts a fixed number of enable ticks and then releases reset, so the core starts executing again.

Firmware can switch off the primary monitor with a disable bit. The monitor is also forced off while the chip is suspended. During either condition, only the brown-out flag can trip a reset. A brown-out trip turns primary supervision back on for the whole recovery. Release then waits for the higher threshold and the full start-up delay, whatever the disable bit says.

A sticky status bit records that a supply reset happened. Power-on counts as such a reset. Only an explicit clear strobe from firmware clears the bit.

Top module: `supply_reset_seq`

## Requirements
- R1: While `rst_i` is high and on the first cycle after it falls, `chip_rst_o` is 1 and `sup_evt_o` is 1.
- R2: While in reset, `chip_rst_o` stays 1 as long as `pri_low_i` is 1. `pri_low_i` is active high, meaning supply is below the high threshold. After the first edge with `pri_low_i` at 0, reset is released on the edge that samples the START_TICKS-th `tick_i` pulse.
- R3: While running, with `pri_off_i`=0 and `suspend_i`=0, `pri_low_i`=1 asserts `chip_rst_o` on the next edge.
- R4: While running, if `pri_off_i`=1 or `suspend_i`=1, `pri_low_i` has no effect on `chip_rst_o`.
- R5: `bo_low_i` is active high, meaning supply is below the low threshold. While running, it asserts `chip_rst_o` on the next edge only when the primary monitor is off (`pri_off_i`=1 or `suspend_i`=1). With the primary monitor on, it is ignored.
- R6: After a brown-out trip, release follows the R2 sequence: wait for `pri_low_i`=0, then START_TICKS ticks. This holds even while `pri_off_i` stays 1.
- R7: If `pri_low_i` returns to 1 during the start-up count, the count is discarded. A fresh full count begins after it falls again.
- R8: Cycles with `tick_i`=0 do not advance the start-up count.
- R9: Every reset trip sets `sup_evt_o` on the same edge that raises `chip_rst_o`. The bit holds until an edge with `evt_clr_i`=1. A trip on the same edge as a clear leaves it set.
- R10: When `suspend_i` falls with `pri_off_i`=0, the primary monitor is active again from that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high power-on reset |
| pri_low_i | input | 1 | Supply below high threshold |
| bo_low_i | input | 1 | Supply below brown-out threshold |
| pri_off_i | input | 1 | Firmware disable of the primary monitor |
| suspend_i | input | 1 | Chip is in suspend |
| tick_i | input | 1 | Start-up delay count enable |
| evt_clr_i | input | 1 | Clear strobe for the status bit |
| chip_rst_o | output | 1 | Chip reset, active high |
| sup_evt_o | output | 1 | Sticky supply-reset status |

## Verification
On every cycle the assertions check the trip rules against the port flags, along with reset holding while the primary flag is low, release only on a tick after the flag is clear, and set/hold/clear behaviour of the status bit. The exact release cycle cannot be seen from one cycle of port values and is left to the bench's scenarios. So are the restart of a partly finished count, the brown-out recovery that ignores the disable bit, and the power-on state.

// File: rtl/srs_pkg.sv
package srs_pkg;

    typedef enum logic [1:0] {
        SEQ_HOLD  = 2'd0,
        SEQ_COUNT = 2'd1,
        SEQ_RUN   = 2'd2
    } seq_state_e;

    typedef struct packed {
        logic pri_low;
        logic bo_low;
        logic pri_off_fw;
        logic suspend;
    } supply_view_t;

    function automatic logic pri_monitor_on(input supply_view_t v);
        return !v.pri_off_fw && !v.suspend;
    endfunction

    function automatic int unsigned cnt_width(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/srs_trip_sel.sv
module srs_trip_sel
    import srs_pkg::*;
(
    input  supply_view_t view_i,
    input  logic         running_i,
    output logic         trip_o
);
    logic pri_on;

    always_comb begin
        pri_on = pri_monitor_on(view_i);
        if (pri_on)
            trip_o = running_i && view_i.pri_low;
        else
            trip_o = running_i && view_i.bo_low;
    end
endmodule

// File: rtl/srs_delay_ctr.sv
module srs_delay_ctr
    import srs_pkg::*;
#(
    parameter int unsigned START_TICKS = 8
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic active_i,
    input  logic tick_i,
    output logic done_o
);
    localparam int unsigned CNT_W = cnt_width(START_TICKS);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(START_TICKS - 1);

    logic [CNT_W-1:0] cnt_q;

    assign done_o = active_i && tick_i && (cnt_q == LAST);

    always_ff @(posedge clk_i) begin
        if (rst_i || !active_i)
            cnt_q <= '0;
        else if (tick_i && !done_o)
            cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/srs_status_flag.sv
module srs_status_flag (
    input  logic clk_i,
    input  logic rst_i,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);
    always_ff @(posedge clk_i) begin
        if (rst_i)
            flag_o <= 1'b1;
        else if (set_i)
            flag_o <= 1'b1;
        else if (clr_i)
            flag_o <= 1'b0;
    end
endmodule

// File: rtl/supply_reset_seq.sv
module supply_reset_seq
    import srs_pkg::*;
#(
    parameter int unsigned START_TICKS = 8
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic pri_low_i,
    input  logic bo_low_i,
    input  logic pri_off_i,
    input  logic suspend_i,
    input  logic tick_i,
    input  logic evt_clr_i,
    output logic chip_rst_o,
    output logic sup_evt_o
);
    seq_state_e   state_q, state_d;
    supply_view_t view;
    logic         trip;
    logic         cnt_done;

    assign view = '{pri_low: pri_low_i, bo_low: bo_low_i,
                    pri_off_fw: pri_off_i, suspend: suspend_i};

    srs_trip_sel u_trip (
        .view_i    (view),
        .running_i (state_q == SEQ_RUN),
        .trip_o    (trip)
    );

    srs_delay_ctr #(.START_TICKS(START_TICKS)) u_delay (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .active_i (state_q == SEQ_COUNT && !pri_low_i),
        .tick_i   (tick_i),
        .done_o   (cnt_done)
    );

    srs_status_flag u_flag (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .set_i  (trip),
        .clr_i  (evt_clr_i),
        .flag_o (sup_evt_o)
    );

    // Recovery always watches the primary flag, whatever the disable bit.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SEQ_HOLD:  if (!pri_low_i) state_d = SEQ_COUNT;
            SEQ_COUNT: if (pri_low_i) state_d = SEQ_HOLD;
                       else if (cnt_done) state_d = SEQ_RUN;
            SEQ_RUN:   if (trip) state_d = SEQ_HOLD;
            default:   state_d = SEQ_HOLD;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) state_q <= SEQ_HOLD;
        else       state_q <= state_d;
    end

    assign chip_rst_o = (state_q != SEQ_RUN);
endmodule

// File: rtl/srs_checker.sv
module srs_checker (
    input logic clk_i,
    input logic rst_i,
    input logic pri_low_i,
    input logic bo_low_i,
    input logic pri_off_i,
    input logic suspend_i,
    input logic tick_i,
    input logic evt_clr_i,
    input logic chip_rst_o,
    input logic sup_evt_o
);
    p_hold_while_low_r2: assert property (@(posedge clk_i) disable iff (rst_i)
        chip_rst_o && pri_low_i |=> chip_rst_o);

    p_release_on_tick_r2: assert property (@(posedge clk_i) disable iff (rst_i)
        $fell(chip_rst_o) |-> $past(tick_i) && !$past(pri_low_i));

    p_primary_trip_r3: assert property (@(posedge clk_i) disable iff (rst_i)
        !chip_rst_o && pri_low_i && !pri_off_i && !suspend_i |=> chip_rst_o);

    p_primary_ignored_r4: assert property (@(posedge clk_i) disable iff (rst_i)
        !chip_rst_o && (pri_off_i || suspend_i) && !bo_low_i |=> !chip_rst_o);

    p_brownout_trip_r5: assert property (@(posedge clk_i) disable iff (rst_i)
        !chip_rst_o && bo_low_i && (pri_off_i || suspend_i) |=> chip_rst_o);

    p_brownout_ignored_r5: assert property (@(posedge clk_i) disable iff (rst_i)
        !chip_rst_o && !pri_low_i && !pri_off_i && !suspend_i |=> !chip_rst_o);

    p_status_on_trip_r9: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(chip_rst_o) |-> sup_evt_o);

    p_status_sticky_r9: assert property (@(posedge clk_i) disable iff (rst_i)
        sup_evt_o && !evt_clr_i |=> sup_evt_o);

    p_status_clear_r9: assert property (@(posedge clk_i) disable iff (rst_i)
        !chip_rst_o && evt_clr_i && !pri_low_i && !bo_low_i |=> !sup_evt_o);
endmodule

bind supply_reset_seq srs_checker chk_i (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .pri_low_i  (pri_low_i),
    .bo_low_i   (bo_low_i),
    .pri_off_i  (pri_off_i),
    .suspend_i  (suspend_i),
    .tick_i     (tick_i),
    .evt_clr_i  (evt_clr_i),
    .chip_rst_o (chip_rst_o),
    .sup_evt_o  (sup_evt_o)
);

// File: tb/supply_reset_seq_tb.sv
module supply_reset_seq_tb_top;
    localparam int unsigned N = 3;

    logic clk = 1'b0;
    logic rst, pri_low, bo_low, pri_off, suspend, tick, evt_clr;
    logic chip_rst, sup_evt;
    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    supply_reset_seq #(.START_TICKS(N)) dut_i (
        .clk_i(clk), .rst_i(rst), .pri_low_i(pri_low), .bo_low_i(bo_low),
        .pri_off_i(pri_off), .suspend_i(suspend), .tick_i(tick),
        .evt_clr_i(evt_clr), .chip_rst_o(chip_rst), .sup_evt_o(sup_evt)
    );

    // bits: [7] pri_low [6] bo_low [5] pri_off [4] suspend [3] tick [2] clr
    //       [1] expected chip_rst [0] expected status, after the edge
    localparam logic [7:0] VEC [0:27] = '{
        8'b1000_0011, // R2 hold while low
        8'b1000_1011, // R2 ticks ignored while low
        8'b0000_1011, // R2 enter count
        8'b0000_1011,
        8'b0000_1011,
        8'b0000_1001, // R2 release on 3rd tick
        8'b0000_0100, // R9 clear
        8'b1010_0000, // R4 disabled by firmware
        8'b1001_0000, // R4 disabled by suspend
        8'b0100_0000, // R5 brown-out ignored, primary on
        8'b1110_0011, // R5 brown-out trip
        8'b1010_1011, // R6 held until primary clear
        8'b0010_1011, // R6 count
        8'b0010_1011,
        8'b0010_1011,
        8'b0010_0011, // R8 no tick, no advance
        8'b0010_1001, // R6 release
        8'b1000_0111, // R3 trip, R9 set beats clear
        8'b0000_1011,
        8'b0000_1011,
        8'b1000_1011, // R7 reassert mid-count
        8'b0000_1011,
        8'b0000_1011,
        8'b0000_1011, // R7 count restarted, still in reset
        8'b0000_1001,
        8'b0000_0100, // R9 clear
        8'b1001_0000, // R10 suspended, ignored
        8'b1000_0011  // R10 suspend ends, primary trips
    };

    task automatic check(input string req, input logic r_exp, input logic s_exp);
        checks++;
        if (chip_rst !== r_exp || sup_evt !== s_exp) begin
            fails++;
            $display("FAIL %s: chip_rst=%b sup_evt=%b expected %b %b",
                     req, chip_rst, sup_evt, r_exp, s_exp);
        end
    endtask

    task automatic drive(input logic [7:0] v);
        {pri_low, bo_low, pri_off, suspend, tick, evt_clr} = v[7:2];
    endtask

    initial begin
        rst = 1'b1;
        drive(8'h00);
        repeat (3) @(posedge clk);
        #1;
        check("R1 in reset", 1'b1, 1'b1);
        pri_low = 1'b1;
        rst = 1'b0;
        @(posedge clk); #1;
        check("R1 after reset", 1'b1, 1'b1);

        for (int i = 0; i < 28; i++) begin
            drive(VEC[i]);
            @(posedge clk); #1;
            check($sformatf("vector %0d", i), VEC[i][1], VEC[i][0]);
        end

        // R1: reset mid-run restores reset and status
        drive(8'b0000_0100);
        @(posedge clk); #1;
        rst = 1'b1;
        drive(8'b0000_1000);
        @(posedge clk); #1;
        check("R1 re-reset", 1'b1, 1'b1);
        rst = 1'b0;

        // R8: long stretch without ticks stays in reset
        drive(8'b0000_0000);
        for (int i = 0; i < 20; i++) @(posedge clk);
        #1;
        check("R8 no ticks", 1'b1, 1'b1);
        tick = 1'b1;
        @(posedge clk); @(posedge clk); #1;
        check("R8 two ticks", 1'b1, 1'b1);
        @(posedge clk); #1;
        check("R2 release after N ticks", 1'b0, 1'b1);

        // R6: brown-out under suspend, release ignores the disable state
        drive(8'b0101_0000);
        @(posedge clk); #1;
        check("R6 suspend brown-out trip", 1'b1, 1'b1);
        drive(8'b0011_1000);
        repeat (N + 1) @(posedge clk);
        #1;
        check("R6 suspend recovery", 1'b0, 1'b1);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end
endmodule